// File: doc/BRIEF.md
# BCD Calendar Clock with Masked Alarm

This block keeps time of day and calendar date in packed BCD and advances them by one second each time a single-cycle tick pulse arrives. Seconds, minutes, hours, day of week, date, month and two-digit year roll over into one another in a single chain. The date follows the month length, and February gains its 29th day in years divisible by four. The hours field runs either as a 24-hour count or as a 12-hour count with a PM flag, selected by a bit stored in the hours byte itself.

A time-of-day alarm compares seconds, minutes, hours and day of week against four alarm bytes. The top bit of each alarm byte removes that field from the comparison. Masking from the day downwards gives repeat rates of weekly, daily, hourly, per minute or per second. A match latches a status flag. The interrupt output is high while that flag is set and the interrupt enable bit is 1. Software reaches every register through a simple address, write-strobe and read-data port. The read data is a combinational function of the address.

Top module: `rtc_calendar_core`

## Requirements
- R1: After a synchronous active-low reset, seconds, minutes and hours read 00 (24-hour mode), day of week, date and month read 01, year reads 00, the four alarm bytes, control and status read 00, and `irq_o` is low.
- R2: Address map: 00 seconds, 01 minutes, 02 hours, 03 day of week, 04 date, 05 month, 06 year, 07–0A alarm seconds/minutes/hours/day, 0B control, 0C status. Undefined bits read 0: day of week keeps bits 2:0, control keeps bits 7,6,5,4,0, and status keeps bit 0. Addresses 0D to 7F read 00 and ignore writes. A write shows on the read port from the next cycle.
- R3: Each advancing tick adds one second in BCD. Seconds 59 wraps to 00 and carries into minutes, and minutes 59 wraps to 00 and carries into hours.
- R4: With hours bit 6 = 0 (24-hour), bits 5:0 count 00 to 23 in BCD, and 23 wraps to 00 with a carry into day and date.
- R5: With hours bit 6 = 1 (12-hour), bits 4:0 hold 01–12 in BCD and bit 5 is PM (1 = PM). 12 goes to 01. 11 goes to 12 and inverts PM. The carry into day and date happens only on 11 PM to 12 AM.
- R6: On a day carry, day of week goes 7 to 1 and otherwise adds one. The date wraps to 01 after 31, after 30 in months 04/06/09/11, and in February after 28, or after 29 when the BCD year is divisible by 4 (00 counts). Month 12 wraps to 01 and carries into the year, and year 99 wraps to 00.
- R7: While control bit 7 is 1, ticks do not advance the time and do not set the alarm flag.
- R8: While control bit 6 is 1, writes to every address other than control are ignored. Control itself stays writable.
- R9: A write strobe in the same cycle as a tick applies the write and drops that tick.
- R10: On an advancing tick, status bit 0 sets when the new time matches every alarm field whose bit 7 is 0. Alarm bits 6:0 are compared with seconds, minutes and the full hours byte, and bits 2:0 with day of week.
- R11: Writing status with bit 0 = 1 clears the flag. Writing it with bit 0 = 0 leaves the flag unchanged, and so does any write blocked by R8.
- R12: `irq_o` is high exactly when status bit 0 and control bit 0 are both 1, starting with the clock edge that sets the later of the two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse, once per second |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 7 | Register address for read and write |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Active-high alarm interrupt |

## Verification
Every register, including the alarm flag, takes its new value on the clock edge where the tick or the write is sampled. Read data is combinational from the address, so a result is visible in the cycle after its stimulus, and `irq_o` is visible from that same edge. The bench applies each stimulus before a rising edge and updates its behavioural model at that edge. It compares `irq_o` at the following falling edge and reads the registers back only after that, never across an edge.

// File: rtl/rtc_pkg.sv
// Package: shared constants, time record type and BCD helpers for the
// calendar clock. Assumes packed-BCD fields with no range checking.
package rtc_pkg;

    localparam int ADDR_W  = 7;
    localparam int DATA_W  = 8;
    localparam int N_ALM   = 4;
    localparam int TIDX_W  = 3;
    localparam int AIDX_W  = $clog2(N_ALM);

    localparam logic [ADDR_W-1:0] A_SEC   = 7'h00;
    localparam logic [ADDR_W-1:0] A_YEAR  = 7'h06;
    localparam logic [ADDR_W-1:0] A_ALM0  = 7'h07;
    localparam logic [ADDR_W-1:0] A_ALM3  = 7'h0A;
    localparam logic [ADDR_W-1:0] A_CTRL  = 7'h0B;
    localparam logic [ADDR_W-1:0] A_STAT  = 7'h0C;

    localparam int CTRL_HALT = 7;
    localparam int CTRL_WP   = 6;
    localparam int CTRL_AIE  = 0;
    localparam logic [DATA_W-1:0] CTRL_KEEP = 8'hF1;

    typedef struct packed {
        logic [6:0] sec;
        logic [6:0] min;
        logic [6:0] hour;
        logic [2:0] dow;
        logic [5:0] date;
        logic [4:0] month;
        logic [7:0] year;
    } rtc_time_t;

    // Add one to a two-digit BCD value (99 gives A0; callers wrap first).
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        else
            return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // Two-digit BCD year divisible by four.
    function automatic logic is_leap(input logic [7:0] y);
        if (y[4] == 1'b0)
            return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
        else
            return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    endfunction

    // Last date of a month, in BCD.
    function automatic logic [5:0] last_date(input logic [4:0] m, input logic [7:0] y);
        case (m)
            5'h02:                      return is_leap(y) ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
            default:                    return 6'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_time_chain.sv
// Module: time and calendar registers with the rollover cascade.
// Computes the next second combinationally (nxt_o) and loads it on adv_i.
// A write has priority over an advance. Assumes the caller never raises
// adv_i and wr_en_i together.
module rtc_time_chain
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv_i,
    input  logic              wr_en_i,
    input  logic [TIDX_W-1:0] wr_idx_i,
    input  logic [DATA_W-1:0] wdata_i,
    output rtc_time_t         cur_o,
    output rtc_time_t         nxt_o
);

    rtc_time_t cur_q;
    rtc_time_t nxt;

    logic [7:0] inc_sec, inc_min, inc_h24, inc_h12, inc_date, inc_mon, inc_yr;
    logic       w_sec, w_min, w_hr, w_date, w_mon;
    logic       c_min, c_hr, c_day, c_mon, c_yr;

    assign inc_sec  = bcd_inc({1'b0, cur_q.sec});
    assign inc_min  = bcd_inc({1'b0, cur_q.min});
    assign inc_h24  = bcd_inc({2'b0, cur_q.hour[5:0]});
    assign inc_h12  = bcd_inc({3'b0, cur_q.hour[4:0]});
    assign inc_date = bcd_inc({2'b0, cur_q.date});
    assign inc_mon  = bcd_inc({3'b0, cur_q.month});
    assign inc_yr   = bcd_inc(cur_q.year);

    // Wrap conditions of each field.
    always_comb begin
        w_sec  = (cur_q.sec == 7'h59);
        w_min  = (cur_q.min == 7'h59);
        w_hr   = cur_q.hour[6] ? ((cur_q.hour[4:0] == 5'h11) && cur_q.hour[5])
                               : (cur_q.hour[5:0] == 6'h23);
        w_date = (cur_q.date == last_date(cur_q.month, cur_q.year));
        w_mon  = (cur_q.month == 5'h12);
    end

    // Carry cascade from seconds up to year.
    always_comb begin
        c_min = w_sec;
        c_hr  = c_min & w_min;
        c_day = c_hr & w_hr;
        c_mon = c_day & w_date;
        c_yr  = c_mon & w_mon;
    end

    // Next-second values of every field.
    always_comb begin
        nxt     = cur_q;
        nxt.sec = w_sec ? 7'h00 : inc_sec[6:0];
        if (c_min)
            nxt.min = w_min ? 7'h00 : inc_min[6:0];
        if (c_hr) begin
            if (cur_q.hour[6]) begin
                case (cur_q.hour[4:0])
                    5'h12:   nxt.hour = {1'b1, cur_q.hour[5], 5'h01};
                    5'h11:   nxt.hour = {1'b1, ~cur_q.hour[5], 5'h12};
                    default: nxt.hour = {1'b1, cur_q.hour[5], inc_h12[4:0]};
                endcase
            end else begin
                nxt.hour = (cur_q.hour[5:0] == 6'h23) ? 7'h00 : {1'b0, inc_h24[5:0]};
            end
        end
        if (c_day) begin
            nxt.dow  = (cur_q.dow == 3'd7) ? 3'd1 : cur_q.dow + 3'd1;
            nxt.date = w_date ? 6'h01 : inc_date[5:0];
        end
        if (c_mon)
            nxt.month = w_mon ? 5'h01 : inc_mon[4:0];
        if (c_yr)
            nxt.year = (cur_q.year == 8'h99) ? 8'h00 : inc_yr;
    end

    // Register update: reset, field write, or one-second advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q.sec   <= 7'h00;
            cur_q.min   <= 7'h00;
            cur_q.hour  <= 7'h00;
            cur_q.dow   <= 3'd1;
            cur_q.date  <= 6'h01;
            cur_q.month <= 5'h01;
            cur_q.year  <= 8'h00;
        end else if (wr_en_i) begin
            case (wr_idx_i)
                3'd0:    cur_q.sec   <= wdata_i[6:0];
                3'd1:    cur_q.min   <= wdata_i[6:0];
                3'd2:    cur_q.hour  <= wdata_i[6:0];
                3'd3:    cur_q.dow   <= wdata_i[2:0];
                3'd4:    cur_q.date  <= wdata_i[5:0];
                3'd5:    cur_q.month <= wdata_i[4:0];
                default: cur_q.year  <= wdata_i;
            endcase
        end else if (adv_i) begin
            cur_q <= nxt;
        end
    end

    assign cur_o = cur_q;
    assign nxt_o = nxt;

endmodule

// File: rtl/rtc_alarm_unit.sv
// Module: alarm bytes, per-field masked comparison and the sticky flag.
// Compares the time that an advance is about to load, so the flag sets
// on the same edge as the new time. Bit 7 of each alarm byte masks its field.
module rtc_alarm_unit
    import rtc_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en_i,
    input  logic [AIDX_W-1:0]            wr_idx_i,
    input  logic [DATA_W-1:0]            wdata_i,
    input  logic                         adv_i,
    input  logic                         clr_i,
    input  logic [6:0]                   sec_i,
    input  logic [6:0]                   min_i,
    input  logic [6:0]                   hour_i,
    input  logic [2:0]                   dow_i,
    output logic [N_ALM-1:0][DATA_W-1:0] alm_o,
    output logic                         flag_o
);

    // Field bits kept per alarm byte (index 0 = seconds ... 3 = day).
    localparam logic [N_ALM-1:0][6:0] FKEEP = {7'h07, 7'h7F, 7'h7F, 7'h7F};

    logic [N_ALM-1:0][DATA_W-1:0] alm_q;
    logic [N_ALM-1:0][6:0]        fval;
    logic [N_ALM-1:0]             hit;
    logic                         flag_q;

    assign fval[0] = sec_i;
    assign fval[1] = min_i;
    assign fval[2] = hour_i;
    assign fval[3] = {4'b0, dow_i};

    for (genvar g = 0; g < N_ALM; g++) begin : g_field
        // Alarm byte storage with its undefined bits cleared.
        always_ff @(posedge clk) begin
            if (!rst_n)
                alm_q[g] <= '0;
            else if (wr_en_i && (wr_idx_i == AIDX_W'(g)))
                alm_q[g] <= wdata_i & {1'b1, FKEEP[g]};
        end
        assign hit[g] = alm_q[g][7] | (alm_q[g][6:0] == fval[g]);
    end

    // Sticky match flag: set on a matching advance, cleared on request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (clr_i)
            flag_q <= 1'b0;
        else if (adv_i && (&hit))
            flag_q <= 1'b1;
    end

    assign alm_o  = alm_q;
    assign flag_o = flag_q;

endmodule

// File: rtl/rtc_calendar_core.sv
// Module: top of the BCD calendar clock. Decodes the register port,
// holds the control byte, gates ticks and drives the interrupt.
// Assumes tick_i is a one-cycle pulse; any write strobe drops a
// coincident tick.
module rtc_calendar_core
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_o
);

    logic [DATA_W-1:0]            ctrl_q;
    rtc_time_t                    t_cur;
    rtc_time_t                    t_nxt;
    logic [N_ALM-1:0][DATA_W-1:0] alm;
    logic                         flag;
    logic                         wr_ok, adv, time_wr, alm_wr, clr;

    // Write qualification and tick gating.
    always_comb begin
        wr_ok   = wr_en_i & (~ctrl_q[CTRL_WP] | (addr_i == A_CTRL));
        adv     = tick_i & ~ctrl_q[CTRL_HALT] & ~wr_en_i;
        time_wr = wr_ok & (addr_i <= A_YEAR);
        alm_wr  = wr_ok & (addr_i >= A_ALM0) & (addr_i <= A_ALM3);
        clr     = wr_ok & (addr_i == A_STAT) & wdata_i[0];
    end

    // Control byte storage.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (wr_ok && (addr_i == A_CTRL))
            ctrl_q <= wdata_i & CTRL_KEEP;
    end

    rtc_time_chain u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv_i    (adv),
        .wr_en_i  (time_wr),
        .wr_idx_i (addr_i[TIDX_W-1:0]),
        .wdata_i  (wdata_i),
        .cur_o    (t_cur),
        .nxt_o    (t_nxt)
    );

    rtc_alarm_unit u_alarm (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (alm_wr),
        .wr_idx_i (addr_i[AIDX_W-1:0] + AIDX_W'(1)),
        .wdata_i  (wdata_i),
        .adv_i    (adv),
        .clr_i    (clr),
        .sec_i    (t_nxt.sec),
        .min_i    (t_nxt.min),
        .hour_i   (t_nxt.hour),
        .dow_i    (t_nxt.dow),
        .alm_o    (alm),
        .flag_o   (flag)
    );

    // Read multiplexer; undefined addresses return zero.
    always_comb begin
        case (addr_i)
            7'h00:   rdata_o = {1'b0, t_cur.sec};
            7'h01:   rdata_o = {1'b0, t_cur.min};
            7'h02:   rdata_o = {1'b0, t_cur.hour};
            7'h03:   rdata_o = {5'b0, t_cur.dow};
            7'h04:   rdata_o = {2'b0, t_cur.date};
            7'h05:   rdata_o = {3'b0, t_cur.month};
            7'h06:   rdata_o = t_cur.year;
            7'h07:   rdata_o = alm[0];
            7'h08:   rdata_o = alm[1];
            7'h09:   rdata_o = alm[2];
            7'h0A:   rdata_o = alm[3];
            7'h0B:   rdata_o = ctrl_q;
            7'h0C:   rdata_o = {7'b0, flag};
            default: rdata_o = '0;
        endcase
    end

    assign irq_o = flag & ctrl_q[CTRL_AIE];

endmodule

// File: rtl/rtc_calendar_core_chk.sv
// Module: assertion checker for rtc_calendar_core, bound to every instance.
module rtc_calendar_core_chk
    import rtc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              tick_i,
    input logic              wr_en_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [DATA_W-1:0] rdata_o,
    input logic              irq_o,
    input logic [DATA_W-1:0] ctrl_q,
    input logic              flag,
    input rtc_time_t         t_cur
);

    // R3: without a tick or a write the time does not move.
    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !wr_en_i) |=> $stable(t_cur));

    // R7: halted clock ignores ticks.
    assert_halt_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[CTRL_HALT] && !wr_en_i) |=> $stable(t_cur));

    // R8: protected writes leave the time untouched.
    assert_protect_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[CTRL_WP] && wr_en_i && addr_i != A_CTRL) |=> $stable(t_cur));

    // R10: the flag only rises on an edge that saw a tick.
    assert_flag_on_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(tick_i));

    // R11: an asserted interrupt persists until some write.
    assert_irq_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !wr_en_i) |=> irq_o);

    // R2: reserved addresses read zero.
    assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i >= 7'h0F) |-> (rdata_o == 8'h00));

endmodule

bind rtc_calendar_core rtc_calendar_core_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (tick_i),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .rdata_o (rdata_o),
    .irq_o   (irq_o),
    .ctrl_q  (ctrl_q),
    .flag    (flag),
    .t_cur   (t_cur)
);

// File: tb/rtc_calendar_core_bench.sv
// Bench: behavioural integer model of the calendar clock, stepped on each
// rising edge and compared with the design at the following falling edge.
module rtc_calendar_core_bench;
    timeunit 1ns;
    timeprecision 100ps;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [6:0] addr_i = '0;
    logic [7:0] wdata_i = '0;
    logic [7:0] rdata_o;
    logic       irq_o;

    int n_chk = 0;
    int n_fail = 0;

    // Model state
    int m_sec, m_min, m_hr, m_dow, m_date, m_mon, m_yr;
    bit m_12;
    logic [7:0] m_alm [4];
    logic [7:0] m_ctrl;
    bit m_flag;

    rtc_calendar_core u_rtc_calendar_core (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
    );

    always #2.5 clk = ~clk;

    function automatic logic [7:0] to_bcd(int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic int from_bcd(logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    function automatic int mlen(int mo, int yr);
        if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    function automatic logic [7:0] hour_byte();
        int h;
        if (!m_12) return to_bcd(m_hr);
        h = m_hr % 12;
        if (h == 0) h = 12;
        return 8'h40 | ((m_hr >= 12) ? 8'h20 : 8'h00) | to_bcd(h);
    endfunction

    function automatic logic [7:0] model_read(logic [6:0] a);
        case (a)
            7'h00: return to_bcd(m_sec);
            7'h01: return to_bcd(m_min);
            7'h02: return hour_byte();
            7'h03: return 8'(m_dow);
            7'h04: return to_bcd(m_date);
            7'h05: return to_bcd(m_mon);
            7'h06: return to_bcd(m_yr);
            7'h07, 7'h08, 7'h09, 7'h0A: return m_alm[a - 7'h07];
            7'h0B: return m_ctrl;
            7'h0C: return {7'b0, m_flag};
            default: return 8'h00;
        endcase
    endfunction

    task automatic model_reset();
        m_sec = 0; m_min = 0; m_hr = 0; m_12 = 0;
        m_dow = 1; m_date = 1; m_mon = 1; m_yr = 0;
        for (int i = 0; i < 4; i++) m_alm[i] = 8'h00;
        m_ctrl = 8'h00; m_flag = 0;
    endtask

    task automatic model_write(logic [6:0] a, logic [7:0] d);
        int h;
        case (a)
            7'h00: m_sec = from_bcd(d & 8'h7F);
            7'h01: m_min = from_bcd(d & 8'h7F);
            7'h02: begin
                m_12 = d[6];
                if (m_12) begin
                    h = from_bcd(d & 8'h1F);
                    m_hr = (h % 12) + (d[5] ? 12 : 0);
                end else m_hr = from_bcd(d & 8'h3F);
            end
            7'h03: m_dow = int'(d & 8'h07);
            7'h04: m_date = from_bcd(d & 8'h3F);
            7'h05: m_mon = from_bcd(d & 8'h1F);
            7'h06: m_yr = from_bcd(d);
            7'h07, 7'h08, 7'h09: m_alm[a - 7'h07] = d;
            7'h0A: m_alm[3] = d & 8'h87;
            7'h0B: m_ctrl = d & 8'hF1;
            7'h0C: if (d[0]) m_flag = 0;
            default: ;
        endcase
    endtask

    task automatic model_advance();
        bit match;
        m_sec++;
        if (m_sec == 60) begin
            m_sec = 0; m_min++;
            if (m_min == 60) begin
                m_min = 0; m_hr++;
                if (m_hr == 24) begin
                    m_hr = 0;
                    m_dow = (m_dow == 7) ? 1 : m_dow + 1;
                    m_date++;
                    if (m_date > mlen(m_mon, m_yr)) begin
                        m_date = 1; m_mon++;
                        if (m_mon == 13) begin
                            m_mon = 1; m_yr = (m_yr + 1) % 100;
                        end
                    end
                end
            end
        end
        match = 1;
        for (int i = 0; i < 4; i++) begin
            logic [7:0] cur;
            cur = model_read(7'(i));
            if (!m_alm[i][7] && (m_alm[i][6:0] != cur[6:0])) match = 0;
        end
        if (match) m_flag = 1;
    endtask

    task automatic check(logic [7:0] act, logic [7:0] exp, string req);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One clock cycle of stimulus; model steps at the edge, irq compared after.
    task automatic cyc(bit t, bit w, logic [6:0] a, logic [7:0] d);
        tick_i = t; wr_en_i = w; addr_i = a; wdata_i = d;
        @(posedge clk);
        if (w) begin
            if (!m_ctrl[6] || a == 7'h0B) model_write(a, d);
        end else if (t && !m_ctrl[7]) begin
            model_advance();
        end
        @(negedge clk);
        tick_i = 0; wr_en_i = 0;
        check({7'b0, irq_o}, {7'b0, m_flag & m_ctrl[0]}, "R12 irq");
    endtask

    task automatic wr(logic [6:0] a, logic [7:0] d);
        cyc(0, 1, a, d);
    endtask

    task automatic tk(int n);
        for (int i = 0; i < n; i++) cyc(1, 0, 7'h00, 8'h00);
    endtask

    task automatic rd(logic [6:0] a, string req);
        addr_i = a;
        #1;
        check(rdata_o, model_read(a), req);
    endtask

    task automatic dump(string req);
        for (int a = 0; a <= 12; a++) rd(7'(a), req);
    endtask

    task automatic set_time(logic [7:0] h, logic [7:0] mi, logic [7:0] s);
        wr(7'h02, h); wr(7'h01, mi); wr(7'h00, s);
    endtask

    task automatic set_cal(logic [7:0] dw, logic [7:0] dt, logic [7:0] mo, logic [7:0] yr);
        wr(7'h03, dw); wr(7'h04, dt); wr(7'h05, mo); wr(7'h06, yr);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        check({7'b0, irq_o}, 8'h00, "R1 irq after reset");
        dump("R1 reset");

        // R2: masking, reserved addresses, control byte
        wr(7'h03, 8'hFF); rd(7'h03, "R2 dow bits");
        wr(7'h20, 8'h55); rd(7'h20, "R2 reserved"); rd(7'h7F, "R2 reserved top");
        rd(7'h0D, "R2 unused"); dump("R2 after reserved write");
        wr(7'h0B, 8'hFF); rd(7'h0B, "R2 ctrl bits");
        wr(7'h0B, 8'h00); rd(7'h0B, "R8 ctrl writable");

        // R3: seconds and minutes rollover
        set_time(8'h09, 8'h59, 8'h58); tk(3); dump("R3 rollover");

        // R4 and R6: midnight into leap February 29
        set_cal(8'h07, 8'h28, 8'h02, 8'h24);
        set_time(8'h23, 8'h59, 8'h59); tk(1); dump("R4 R6 leap 28");
        set_time(8'h23, 8'h59, 8'h59); tk(1); dump("R6 leap 29");
        set_cal(8'h03, 8'h28, 8'h02, 8'h23);
        set_time(8'h23, 8'h59, 8'h59); tk(1); dump("R6 common feb");
        set_cal(8'h05, 8'h28, 8'h02, 8'h00);
        set_time(8'h23, 8'h59, 8'h59); tk(1); dump("R6 year 00");
        set_cal(8'h02, 8'h31, 8'h12, 8'h99);
        set_time(8'h23, 8'h59, 8'h59); tk(1); dump("R6 year wrap");
        set_cal(8'h04, 8'h30, 8'h04, 8'h10);
        set_time(8'h23, 8'h59, 8'h59); tk(1); dump("R6 30 day");

        // R5: 12-hour mode
        set_cal(8'h01, 8'h15, 8'h06, 8'h10);
        set_time(8'h71, 8'h59, 8'h59); tk(1); dump("R5 11PM to 12AM");
        set_time(8'h51, 8'h59, 8'h59); tk(1); dump("R5 11AM to 12PM");
        set_time(8'h52, 8'h59, 8'h59); tk(1); dump("R5 12 to 1");

        // R7: halt
        wr(7'h02, 8'h10); wr(7'h0B, 8'h80); tk(5); dump("R7 halted");
        wr(7'h0B, 8'h00); tk(1); dump("R7 resumed");

        // R8: write protect
        wr(7'h0B, 8'h40); wr(7'h00, 8'h33); wr(7'h07, 8'h81); wr(7'h06, 8'h55);
        dump("R8 protected");
        wr(7'h0B, 8'h00); wr(7'h00, 8'h33); dump("R8 unprotected");

        // R9: write with coincident tick
        cyc(1, 1, 7'h00, 8'h10); dump("R9 write wins");

        // R10/R11/R12: all masked, once per second
        wr(7'h07, 8'h80); wr(7'h08, 8'h80); wr(7'h09, 8'h80); wr(7'h0A, 8'h80);
        wr(7'h0B, 8'h01); tk(1); dump("R10 every second");
        wr(7'h0C, 8'h00); dump("R11 write zero keeps");
        wr(7'h0B, 8'h41); wr(7'h0C, 8'h01); dump("R11 protected clear");
        wr(7'h0B, 8'h01); wr(7'h0C, 8'h01); dump("R11 clear");

        // R10: seconds match
        wr(7'h07, 8'h05); wr(7'h00, 8'h00); tk(4); dump("R10 before sec match");
        tk(1); dump("R10 sec match");
        wr(7'h0C, 8'h01);

        // R10: minutes and seconds match
        wr(7'h07, 8'h00); wr(7'h08, 8'h01);
        set_time(8'h10, 8'h00, 8'h58); tk(1); dump("R10 min no match");
        tk(1); dump("R10 min match");
        wr(7'h0C, 8'h01);

        // R10/R12: full weekly match with interrupt disabled first
        wr(7'h0B, 8'h00);
        wr(7'h08, 8'h00); wr(7'h09, 8'h00); wr(7'h0A, 8'h02);
        wr(7'h03, 8'h01); set_time(8'h23, 8'h59, 8'h58); tk(2);
        dump("R10 weekly match AIE off");
        wr(7'h0B, 8'h01); dump("R12 enable raises irq");
        wr(7'h0A, 8'h03); wr(7'h0C, 8'h01);
        wr(7'h03, 8'h01); set_time(8'h23, 8'h59, 8'h58); tk(2);
        dump("R10 day mismatch");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule